// File: doc/BRIEF.md
# Interleaved Address Range Decoder

This block turns a physical address into a routing decision for a memory subsystem. It holds a small ordered table of address-range rules. Each rule has an enable, a way-hashing mode, an upper limit and a list of eight 2-bit targets. The first enabled rule whose range covers the address is chosen. Its mode hashes the address into a way index from 0 to 7, and the way selects one entry of the target list. That entry is the logical target. The block reports it in three forms: the raw target, a node decode of the raw code, and a physical channel.

The physical channel comes from a mapper. The mapper holds a 3-bit code for each logical target and each direction (read or write). Besides plain one-to-one codes, the mapper has codes for a channel that is spared onto channel 2, and a code for a mirrored pair. For a mirrored pair, reads are spread over channels 0 and 1 by address parity. The block also reports how many distinct targets the chosen rule's list names.

Software loads the tables through a single-cycle register write port. Lookups are accepted on any cycle, and the result appears one clock later. The control flow has two states per cycle: a cycle is either a lookup (LOOKUP, when `req_valid` is high) or idle (IDLE). The output register follows that choice on each edge: LOOKUP→HIT when a legal rule matches, and LOOKUP→MISS or IDLE→MISS otherwise. MISS drives all outputs to zero.

Top module: `range_interleave_decoder`

## Requirements
- R1: Rules are searched from index 0 upward. The lower bound of rule i is the limit of rule i-1, or zero for rule 0, and this holds whether or not rule i-1 is enabled. A rule hits when it is enabled and lower bound <= address < limit. Limits are in units of 2^24 bytes.
- R2: In mode 0 the way is address bits [8:6].
- R3: In mode 1 the way is address bits [8:6] XOR address bits [18:16].
- R4: In mode 2, way bit 2 is address bit 6, and way bits [1:0] are address bits [39:6] taken modulo 3.
- R5: A hitting rule with mode 3 gives an invalid result: `rsp_valid` is low and every output is zero.
- R6: The target list holds eight 4-bit fields. The target for way j is list bits [4j+1:4j], and list bits [4j+3:4j+2] have no effect.
- R7: `rsp_node_ok` is high with `rsp_node`=0 for target code 1, and high with `rsp_node`=1 for target code 2. For target codes 0 and 3, `rsp_node_ok` is low and `rsp_node` is 0.
- R8: The mapper code is mapper bits [3(2t+w)+2 : 3(2t+w)], where t is the target and w is 1 for writes. Code 1 selects channel 0, code 2 selects channel 1, and code 4 selects channel 2.
- R9: Spare codes: code 5 selects channel 0 and code 6 selects channel 1.
- R10: Code 3 is a mirrored pair. A read selects channel 1 when address bits 24, 12 and 6 have odd parity, and channel 0 otherwise. A write selects channel 0.
- R11: Codes 0 and 7 leave `rsp_chan_ok` low and `rsp_channel` at zero, while `rsp_valid` stays high.
- R12: `rsp_ways` equals the number of distinct target codes among the eight list entries of the chosen rule, a value from 1 to 4.
- R13: Results are registered with one cycle of latency. With no request or no hit, `rsp_valid` is low and all outputs are zero.
- R14: The meaning of `cfg_addr` depends on its value:
  - Word 2i sets rule i's control: bit 31 is the enable, bits [17:16] the mode and bits [15:0] the limit.
  - Word 2i+1 sets rule i's target list.
  - Word 16 sets the mapper from bits [23:0].
  - Writes to any other address have no effect.
  - Reset clears every rule and the mapper.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 5 | Table word select |
| cfg_wdata | input | 32 | Table write data |
| req_valid | input | 1 | Lookup request |
| req_write | input | 1 | Lookup direction, 1 = write |
| req_addr | input | 40 | Physical address |
| rsp_valid | output | 1 | Legal rule hit for last cycle's request |
| rsp_target | output | 2 | Logical target from the list |
| rsp_ways | output | 3 | Distinct targets in the chosen list |
| rsp_node | output | 1 | Decoded node |
| rsp_node_ok | output | 1 | Target code is a node code |
| rsp_channel | output | 2 | Physical channel |
| rsp_chan_ok | output | 1 | Mapper code selects a channel |

## Verification
The bench probes the points where a wrong design would still give a plausible answer:
- A disabled rule sitting between two enabled ones. A decoder that skipped the disabled rule's limit when forming the next lower bound would hit where it must miss.
- Mode 2 addresses chosen so that the correct result differs from the mode 0 and mode 1 result. A wrong remainder or a misplaced bit 2 then lands on a different target.
- Target lists with the upper nibble bits set, which a decoder using the wrong field width would misread.
- Mirror reads at both parities, and every spare, direct and illegal mapper code. A swapped code would route to the wrong channel or report a channel where none exists.
- The rule edge at a limit, a mode 3 rule, and writes to unused table words. These show up as spurious hits or corrupted routing.

// File: rtl/ardec_pkg.sv
package ardec_pkg;
    localparam int ADDR_W    = 40;
    localparam int LIMIT_LSB = 24;
    localparam int LIMIT_W   = ADDR_W - LIMIT_LSB;
    localparam int LINE_LSB  = 6;
    localparam int LINE_W    = ADDR_W - LINE_LSB;
    localparam int NWAYS     = 8;
    localparam int TGT_W     = 2;
    localparam int NTGT      = 1 << TGT_W;
    localparam int CODE_W    = 3;
    localparam int MAP_W     = NTGT * 2 * CODE_W;

    typedef enum logic [1:0] {
        HASH_LOW  = 2'd0,
        HASH_XOR  = 2'd1,
        HASH_MOD3 = 2'd2,
        HASH_BAD  = 2'd3
    } hash_mode_e;

    typedef enum logic [2:0] {
        MAP_NONE  = 3'd0,
        MAP_CH0   = 3'd1,
        MAP_CH1   = 3'd2,
        MAP_MIRR  = 3'd3,
        MAP_CH2   = 3'd4,
        MAP_SPR0  = 3'd5,
        MAP_SPR1  = 3'd6,
        MAP_RSVD  = 3'd7
    } map_code_e;
endpackage

// File: rtl/rid_rule_match.sv
module rid_rule_match
    import ardec_pkg::*;
#(
    parameter int NUM_RULES = 8,
    localparam int IDX_W = $clog2(NUM_RULES)
) (
    input  logic [NUM_RULES-1:0]              rule_en,
    input  logic [NUM_RULES-1:0][LIMIT_W-1:0] rule_lim,
    input  logic [LIMIT_W-1:0]                addr_hi,
    output logic                              hit,
    output logic [IDX_W-1:0]                  hit_idx
);
    logic [NUM_RULES-1:0] in_range;

    for (genvar i = 0; i < NUM_RULES; i++) begin : g_cmp
        if (i == 0) begin : g_first
            assign in_range[i] = rule_en[i] && (addr_hi < rule_lim[i]);
        end else begin : g_rest
            assign in_range[i] = rule_en[i] && (addr_hi >= rule_lim[i-1])
                                 && (addr_hi < rule_lim[i]);
        end
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_RULES - 1; i >= 0; i--) begin
            if (in_range[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rid_way_hash.sv
module rid_way_hash
    import ardec_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic [LINE_W-1:0] line,
    output logic [2:0]        way,
    output logic              legal
);
    localparam int SUM_W = $clog2(LINE_W * 2 + 1);

    logic [SUM_W-1:0] wsum;
    logic [1:0]       rem3;

    // 2^k mod 3 alternates 1, 2: weight each line bit accordingly
    always_comb begin
        wsum = '0;
        for (int k = 0; k < LINE_W; k++) begin
            if (line[k]) wsum = wsum + ((k % 2 == 1) ? SUM_W'(2) : SUM_W'(1));
        end
        rem3 = 2'(wsum % SUM_W'(3));
    end

    always_comb begin
        way   = '0;
        legal = 1'b1;
        unique case (hash_mode_e'(mode))
            HASH_LOW:  way = line[2:0];
            HASH_XOR:  way = line[2:0] ^ line[12:10];
            HASH_MOD3: way = {line[0], rem3};
            HASH_BAD:  legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/rid_chan_map.sv
module rid_chan_map
    import ardec_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              is_write,
    input  logic              mirror_odd,
    output logic [1:0]        channel,
    output logic              ok
);
    always_comb begin
        channel = 2'd0;
        ok      = 1'b1;
        unique case (map_code_e'(code))
            MAP_CH0,  MAP_SPR0: channel = 2'd0;
            MAP_CH1,  MAP_SPR1: channel = 2'd1;
            MAP_CH2:            channel = 2'd2;
            MAP_MIRR:           channel = (!is_write && mirror_odd) ? 2'd1 : 2'd0;
            MAP_NONE, MAP_RSVD: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/range_interleave_decoder.sv
module range_interleave_decoder
    import ardec_pkg::*;
#(
    parameter int NUM_RULES = 8,
    localparam int IDX_W = $clog2(NUM_RULES),
    localparam int CFG_AW = $clog2(2 * NUM_RULES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [TGT_W-1:0]  rsp_target,
    output logic [2:0]        rsp_ways,
    output logic              rsp_node,
    output logic              rsp_node_ok,
    output logic [1:0]        rsp_channel,
    output logic              rsp_chan_ok
);
    localparam int MAP_SEL = 2 * NUM_RULES;

    typedef enum logic [1:0] {ST_MISS, ST_HIT} out_state_e;

    logic [NUM_RULES-1:0]              rule_en;
    logic [NUM_RULES-1:0][1:0]         rule_mode;
    logic [NUM_RULES-1:0][LIMIT_W-1:0] rule_lim;
    logic [NUM_RULES-1:0][31:0]        rule_list;
    logic [MAP_W-1:0]                  mapper;

    logic unused_cfg_bits, unused_addr_bits;
    assign unused_cfg_bits  = ^{cfg_wdata[30:18], cfg_wdata[31:MAP_W]};
    assign unused_addr_bits = ^req_addr[LINE_LSB-1:0];

    // table write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rule_en   <= '0;
            rule_mode <= '0;
            rule_lim  <= '0;
            rule_list <= '0;
            mapper    <= '0;
        end else if (cfg_we) begin
            if (32'(cfg_addr) < MAP_SEL) begin
                if (cfg_addr[0]) begin
                    rule_list[cfg_addr[CFG_AW-1:1]] <= cfg_wdata;
                end else begin
                    rule_en[cfg_addr[CFG_AW-1:1]]   <= cfg_wdata[31];
                    rule_mode[cfg_addr[CFG_AW-1:1]] <= cfg_wdata[17:16];
                    rule_lim[cfg_addr[CFG_AW-1:1]]  <= cfg_wdata[LIMIT_W-1:0];
                end
            end else if (32'(cfg_addr) == MAP_SEL) begin
                mapper <= cfg_wdata[MAP_W-1:0];
            end
        end
    end

    logic             hit;
    logic [IDX_W-1:0] hit_idx;

    rid_rule_match #(.NUM_RULES(NUM_RULES)) u_match (
        .rule_en (rule_en),
        .rule_lim(rule_lim),
        .addr_hi (req_addr[ADDR_W-1:LIMIT_LSB]),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    logic [2:0] way;
    logic       mode_legal;

    rid_way_hash u_hash (
        .mode (rule_mode[hit_idx]),
        .line (req_addr[ADDR_W-1:LINE_LSB]),
        .way  (way),
        .legal(mode_legal)
    );

    logic [31:0]       sel_list;
    logic [TGT_W-1:0]  target;
    logic [NTGT-1:0]   present;
    logic [CODE_W-1:0] code;

    assign sel_list = rule_list[hit_idx];
    assign target   = sel_list[{way, 2'b00} +: TGT_W];
    assign code     = mapper[CODE_W * {target, req_write} +: CODE_W];

    for (genvar v = 0; v < NTGT; v++) begin : g_present
        logic [NWAYS-1:0] eq;
        for (genvar j = 0; j < NWAYS; j++) begin : g_way
            assign eq[j] = (sel_list[4*j +: TGT_W] == TGT_W'(v));
        end
        assign present[v] = |eq;
    end

    logic [1:0] channel;
    logic       chan_ok;

    rid_chan_map u_map (
        .code      (code),
        .is_write  (req_write),
        .mirror_odd(req_addr[24] ^ req_addr[12] ^ req_addr[6]),
        .channel   (channel),
        .ok        (chan_ok)
    );

    out_state_e next_state;

    always_comb begin
        next_state = (req_valid && hit && mode_legal) ? ST_HIT : ST_MISS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_target  <= '0;
            rsp_ways    <= '0;
            rsp_node    <= 1'b0;
            rsp_node_ok <= 1'b0;
            rsp_channel <= '0;
            rsp_chan_ok <= 1'b0;
        end else begin
            unique case (next_state)
                ST_HIT: begin
                    rsp_valid   <= 1'b1;
                    rsp_target  <= target;
                    rsp_ways    <= 3'($countones(present));
                    rsp_node    <= (target == 2'd2);
                    rsp_node_ok <= (target == 2'd1) || (target == 2'd2);
                    rsp_channel <= chan_ok ? channel : 2'd0;
                    rsp_chan_ok <= chan_ok;
                end
                default: begin
                    rsp_valid   <= 1'b0;
                    rsp_target  <= '0;
                    rsp_ways    <= '0;
                    rsp_node    <= 1'b0;
                    rsp_node_ok <= 1'b0;
                    rsp_channel <= '0;
                    rsp_chan_ok <= 1'b0;
                end
            endcase
        end
    end

    assert_miss_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_target == 0 && rsp_ways == 0 && !rsp_chan_ok && !rsp_node_ok));
    assert_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));
    assert_ways_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_ways >= 3'd1 && rsp_ways <= 3'd4));
    assert_chan_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_chan_ok |-> (rsp_channel != 2'd3 && rsp_valid));
    assert_node_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_node_ok |-> (rsp_target != 2'd0 && rsp_target != 2'd3));
endmodule

// File: tb/test_range_interleave_decoder.sv
module test_range_interleave_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [39:0] req_addr = '0;
    logic        rsp_valid, rsp_node, rsp_node_ok, rsp_chan_ok;
    logic [1:0]  rsp_target, rsp_channel;
    logic [2:0]  rsp_ways;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    range_interleave_decoder i_range_interleave_decoder (.*);

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] ctl(input logic en, input logic [1:0] m, input logic [15:0] lim);
        return {en, 13'd0, m, lim};
    endfunction

    task automatic lookup(input logic [39:0] a, input logic wr);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // expected: valid, target, ways, node_ok, node, chan_ok, channel
    task automatic expect_rsp(input string tag, input int v, input int t, input int w,
                              input int nok, input int n, input int cok, input int ch);
        check({tag, " valid"}, int'(rsp_valid), v);
        check({tag, " target"}, int'(rsp_target), t);
        check({tag, " ways"}, int'(rsp_ways), w);
        check({tag, " node_ok"}, int'(rsp_node_ok), nok);
        check({tag, " node"}, int'(rsp_node), n);
        check({tag, " chan_ok"}, int'(rsp_chan_ok), cok);
        check({tag, " channel"}, int'(rsp_channel), ch);
    endtask

    task automatic t_reset();
        lookup(40'h0, 1'b0);
        expect_rsp("R13 R14 reset miss", 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_load();
        cfg_write(5'd0,  ctl(1, 2'd0, 16'd1)); cfg_write(5'd1,  32'h32103210);
        cfg_write(5'd2,  ctl(0, 2'd0, 16'd2)); cfg_write(5'd3,  32'h11111111);
        cfg_write(5'd4,  ctl(1, 2'd1, 16'd3)); cfg_write(5'd5,  32'h76543210);
        cfg_write(5'd6,  ctl(1, 2'd2, 16'd4)); cfg_write(5'd7,  32'h03213210);
        cfg_write(5'd8,  ctl(1, 2'd3, 16'd5)); cfg_write(5'd9,  32'h32103210);
        cfg_write(5'd10, ctl(1, 2'd0, 16'd6)); cfg_write(5'd11, 32'h11111111);
        cfg_write(5'd12, ctl(1, 2'd0, 16'd7)); cfg_write(5'd13, 32'h00000022);
        // mapper: t0 rd1 wr2, t1 rd3 wr3, t2 rd5 wr6, t3 rd4 wr7
        cfg_write(5'd16, {8'd0, 3'd7, 3'd4, 3'd6, 3'd5, 3'd3, 3'd3, 3'd2, 3'd1});
    endtask

    task automatic t_mode0_codes();
        lookup(40'h0, 1'b0);    expect_rsp("R2 R8 way0 rd", 1, 0, 4, 0, 0, 1, 0);
        lookup(40'h0, 1'b1);    expect_rsp("R8 way0 wr", 1, 0, 4, 0, 0, 1, 1);
        lookup(40'h80, 1'b0);   expect_rsp("R9 R7 spare rd", 1, 2, 4, 1, 1, 1, 0);
        lookup(40'h80, 1'b1);   expect_rsp("R9 spare wr", 1, 2, 4, 1, 1, 1, 1);
        lookup(40'hC0, 1'b0);   expect_rsp("R8 ch2 rd", 1, 3, 4, 0, 0, 1, 2);
        lookup(40'hC0, 1'b1);   expect_rsp("R11 code7", 1, 3, 4, 0, 0, 0, 0);
    endtask

    task automatic t_mirror();
        lookup(40'h140, 1'b0);  expect_rsp("R10 R7 odd rd", 1, 1, 4, 1, 0, 1, 1);
        lookup(40'h1140, 1'b0); expect_rsp("R10 even rd", 1, 1, 4, 1, 0, 1, 0);
        lookup(40'h140, 1'b1);  expect_rsp("R10 wr", 1, 1, 4, 1, 0, 1, 0);
    endtask

    task automatic t_ranges();
        lookup(40'hFF_FFC0, 1'b0);   expect_rsp("R1 top of rule0", 1, 3, 4, 0, 0, 1, 2);
        lookup(40'h180_0000, 1'b0);  expect_rsp("R1 disabled gap", 0, 0, 0, 0, 0, 0, 0);
        lookup(40'h100_0000, 1'b0);  expect_rsp("R1 at limit", 0, 0, 0, 0, 0, 0, 0);
        lookup(40'h80_0000_0000 - 40'h40, 1'b0);
        expect_rsp("R1 above all", 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_mode1();
        lookup(40'h203_0140, 1'b0); expect_rsp("R3 R6 xor way6", 1, 2, 4, 1, 1, 1, 0);
        lookup(40'h205_0140, 1'b0); expect_rsp("R3 xor way0", 1, 0, 4, 0, 0, 1, 0);
    endtask

    task automatic t_mode2();
        lookup(40'h300_0000, 1'b0); expect_rsp("R4 way0", 1, 0, 4, 0, 0, 1, 0);
        lookup(40'h300_0040, 1'b0); expect_rsp("R4 way5", 1, 2, 4, 1, 1, 1, 0);
        lookup(40'h300_00C0, 1'b0); expect_rsp("R4 way4", 1, 1, 4, 1, 0, 1, 0);
        lookup(40'h300_0140, 1'b0); expect_rsp("R4 way6", 1, 3, 4, 0, 0, 1, 2);
    endtask

    task automatic t_mode3_ways();
        lookup(40'h400_0000, 1'b0); expect_rsp("R5 bad mode", 0, 0, 0, 0, 0, 0, 0);
        lookup(40'h500_0000, 1'b0); expect_rsp("R12 one way", 1, 1, 1, 1, 0, 1, 1);
        lookup(40'h600_0040, 1'b0); expect_rsp("R12 two ways", 1, 2, 2, 1, 1, 1, 0);
    endtask

    task automatic t_idle();
        lookup(40'h0, 1'b0);
        @(negedge clk);
        expect_rsp("R13 idle cycle", 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_cfg_ignore();
        cfg_write(5'd20, 32'hFFFFFFFF);
        cfg_write(5'd31, 32'hFFFFFFFF);
        lookup(40'h80, 1'b0); expect_rsp("R14 unused word", 1, 2, 4, 1, 1, 1, 0);
        cfg_write(5'd0, ctl(0, 2'd0, 16'd1));
        lookup(40'h80, 1'b0); expect_rsp("R14 rule off", 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_mode0_codes();
        t_mirror();
        t_ranges();
        t_mode1();
        t_mode2();
        t_mode3_ways();
        t_idle();
        t_cfg_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule